// File: doc/BRIEF.md
# Performance Event Counter Unit

This block is a processor-side performance monitor. It holds one free-running cycle counter and four event counters, each 32 bits wide. Software reaches all state through a flat register port: a 4-bit word address, a write strobe, 32-bit write data and combinational read data. Up to 128 single-cycle event strobes come in from the surrounding pipeline. Each event counter is programmed with the index of the strobe it watches. One interrupt line tells software that a counter it cares about has wrapped.

Counting is gated twice: by a global run bit in the control word and by a per-counter enable. Enables are changed through separate set and clear addresses, so software never needs a read-modify-write. The event counters sit behind a select register: the type and count addresses act on whichever counter is selected. A profiler typically preloads a counter with the negative of its sample period and takes the overflow interrupt. It then reads and clears the sticky flags and reloads the counter.

Top module: `perf_mon_unit`

Address map (word address on `reg_addr`): 0 control, 1 enable set, 2 enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 overflow flags, 6 counter select, 7 cycle count, 8 selected event type, 9 selected event count. Any other address reads zero.

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Control (address 0) stores bit 0 (run), bit 3 (cycle divide by 64), bit 4 (export) and bit 5 (debug gate). Bits 1 and 2 always read zero. Bits 31..6 read zero.
- R3: Writing control with bit 1 set zeroes all four event counts and leaves the cycle count unchanged. Writing control with bit 2 set zeroes the cycle count and its divide-by-64 prescaler.
- R4: In the enable, interrupt-enable and flag words, bits 0..3 belong to event counters 0..3 and bit 31 to the cycle counter. Other bits read zero. A one written to address 1 or 3 sets that enable. A one written to address 2 or 4 clears it. Zero bits leave the enable alone. Addresses 1 and 2 both read the counter enables, and addresses 3 and 4 both read the interrupt enables.
- R5: A counter advances only while control bit 0 and its own enable bit are both set.
- R6: Event counter i adds one on each clock edge at which `evt_in[type_i]` is high, where type_i is its 7-bit event type.
- R7: With control bit 3 clear, the cycle counter adds one per counting clock. With it set, the cycle counter adds one per 64 counting clocks, the first step coming on the 64th.
- R8: A counter that steps from 0xFFFFFFFF to 0 sets its flag. Flags are sticky and cleared by writing a one to that bit at address 5. If a wrap and a clear of the same flag fall in one cycle, the flag stays set.
- R9: `irq` is high exactly while some flag is set together with its interrupt-enable bit.
- R10: Select (address 6) keeps 5 bits. Addresses 8 (7-bit type) and 9 (count) access the selected event counter. While select is above 3, both addresses read zero and ignore writes.
- R11: The cycle count and the selected event count are writable. A write in the same cycle as an increment takes the written value, with no step added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 128 | Event strobes, one per event type |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of functions can collide in one cycle. A counter wrap can coincide with a software write-one-to-clear of that same flag. A software load of a count can coincide with an event that would increment it. The first pair is provoked by preloading 0xFFFFFFFF while the watched strobe is held high and issuing the flag clear on the very next cycle. It passes only if the flag still reads set and `irq` stays high. The second pair is provoked by writing a count on the first edge at which its strobe is high and dropping the strobe right after. It passes only if the count reads exactly the written value.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CEN_SET = 4'd1;
  localparam logic [ADDR_W-1:0] A_CEN_CLR = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN_SET = 4'd3;
  localparam logic [ADDR_W-1:0] A_IEN_CLR = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 4'd5;
  localparam logic [ADDR_W-1:0] A_SEL     = 4'd6;
  localparam logic [ADDR_W-1:0] A_CYC     = 4'd7;
  localparam logic [ADDR_W-1:0] A_ETYPE   = 4'd8;
  localparam logic [ADDR_W-1:0] A_ECNT    = 4'd9;

  localparam int CTRL_W     = 6;
  localparam int CB_RUN     = 0;
  localparam int CB_RST_EVT = 1;
  localparam int CB_RST_CYC = 2;
  localparam int CB_DIV     = 3;
  // bits kept in the control word; the two reset pulses are never stored
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 6'h39;
  // bus position of the cycle counter in the per-counter words
  localparam int CYC_BIT = 31;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // priority: clear, then software load, then step
  always_comb begin
    cnt_en = clr | ld | inc;
    if (clr)      cnt_d = '0;
    else if (ld)  cnt_d = ld_val;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = inc & ~clr & ~ld & (&cnt_q);
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int LOG2_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  logic [LOG2_DIV-1:0] pre_q, pre_d;
  logic                pre_en;

  always_comb begin
    pre_en = clr | run;
    pre_d  = clr ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  assign tick = run & ~clr & (&pre_q);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int CNT_W    = 32,
  parameter int EVT_IN_W = 128,
  parameter int ETYPE_W  = 7,
  parameter int SEL_W    = 5,
  parameter int LOG2_DIV = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [EVT_IN_W-1:0] evt_in,
  output logic                irq
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int VEC_W = NUM_EVT + 1;   // event counters, then cycle counter

  function automatic logic [VEC_W-1:0] bus2vec(input logic [DATA_W-1:0] w);
    bus2vec = {w[CYC_BIT], w[NUM_EVT-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] vec2bus(input logic [VEC_W-1:0] v);
    vec2bus                = '0;
    vec2bus[CYC_BIT]       = v[NUM_EVT];
    vec2bus[NUM_EVT-1:0]   = v[NUM_EVT-1:0];
  endfunction

  logic [CTRL_W-1:0]                ctrl_q, ctrl_d;
  logic [VEC_W-1:0]                 cen_q, cen_d, ien_q, ien_d, flg_q, flg_d;
  logic [SEL_W-1:0]                 sel_q, sel_d;
  logic [NUM_EVT-1:0][ETYPE_W-1:0]  etype_q, etype_d;
  logic [NUM_EVT-1:0][CNT_W-1:0]    ev_cnt;
  logic [NUM_EVT-1:0]               ev_wrap, ev_ld, ev_inc;
  logic [CNT_W-1:0]                 cyc_cnt;
  logic                             cyc_wrap, cyc_inc, cyc_gate, pre_tick;
  logic [VEC_W-1:0]                 wrap_vec;
  logic                             wr_ctrl, wr_sel, wr_cyc, wr_etype, wr_ecnt;
  logic                             rst_evt, rst_cyc, glb_run, sel_ok;
  logic [IDX_W-1:0]                 sel_idx;
  logic [VEC_W-1:0]                 wmask;

  // ---------------- write decode ----------------
  always_comb begin
    wr_ctrl  = reg_we & (reg_addr == A_CTRL);
    wr_sel   = reg_we & (reg_addr == A_SEL);
    wr_cyc   = reg_we & (reg_addr == A_CYC);
    sel_ok   = (sel_q < SEL_W'(NUM_EVT));
    sel_idx  = sel_q[IDX_W-1:0];
    wr_etype = reg_we & (reg_addr == A_ETYPE) & sel_ok;
    wr_ecnt  = reg_we & (reg_addr == A_ECNT) & sel_ok;
    rst_evt  = wr_ctrl & reg_wdata[CB_RST_EVT];
    rst_cyc  = wr_ctrl & reg_wdata[CB_RST_CYC];
    glb_run  = ctrl_q[CB_RUN];
    wmask    = bus2vec(reg_wdata);
  end

  // ---------------- next state of the control registers ----------------
  always_comb begin
    ctrl_d  = wr_ctrl ? (reg_wdata[CTRL_W-1:0] & CTRL_KEEP) : ctrl_q;
    cen_d   = cen_q;
    ien_d   = ien_q;
    if (reg_we && reg_addr == A_CEN_SET) cen_d = cen_q | wmask;
    if (reg_we && reg_addr == A_CEN_CLR) cen_d = cen_q & ~wmask;
    if (reg_we && reg_addr == A_IEN_SET) ien_d = ien_q | wmask;
    if (reg_we && reg_addr == A_IEN_CLR) ien_d = ien_q & ~wmask;
    // a wrap in the clearing cycle wins over the clear
    flg_d   = (flg_q & ~((reg_we && reg_addr == A_FLAGS) ? wmask : '0)) | wrap_vec;
    sel_d   = wr_sel ? reg_wdata[SEL_W-1:0] : sel_q;
    etype_d = etype_q;
    if (wr_etype) etype_d[sel_idx] = reg_wdata[ETYPE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cen_q   <= '0;
      ien_q   <= '0;
      flg_q   <= '0;
      sel_q   <= '0;
      etype_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      cen_q   <= cen_d;
      ien_q   <= ien_d;
      flg_q   <= flg_d;
      sel_q   <= sel_d;
      etype_q <= etype_d;
    end
  end

  // ---------------- event counters ----------------
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign ev_ld[i]  = wr_ecnt & (sel_idx == IDX_W'(i));
    assign ev_inc[i] = glb_run & cen_q[i] & evt_in[etype_q[i]];

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (rst_evt),
      .ld     (ev_ld[i]),
      .ld_val (reg_wdata[CNT_W-1:0]),
      .inc    (ev_inc[i]),
      .cnt    (ev_cnt[i]),
      .wrap   (ev_wrap[i])
    );
  end

  // ---------------- cycle counter ----------------
  assign cyc_gate = glb_run & cen_q[NUM_EVT];
  assign cyc_inc  = cyc_gate & (ctrl_q[CB_DIV] ? pre_tick : 1'b1);

  pmu_prescaler #(.LOG2_DIV(LOG2_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rst_cyc),
    .run   (cyc_gate & ctrl_q[CB_DIV]),
    .tick  (pre_tick)
  );

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (rst_cyc),
    .ld     (wr_cyc),
    .ld_val (reg_wdata[CNT_W-1:0]),
    .inc    (cyc_inc),
    .cnt    (cyc_cnt),
    .wrap   (cyc_wrap)
  );

  assign wrap_vec = {cyc_wrap, ev_wrap};
  assign irq      = |(flg_q & ien_q);

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:               reg_rdata[CTRL_W-1:0] = ctrl_q;
      A_CEN_SET, A_CEN_CLR: reg_rdata = vec2bus(cen_q);
      A_IEN_SET, A_IEN_CLR: reg_rdata = vec2bus(ien_q);
      A_FLAGS:              reg_rdata = vec2bus(flg_q);
      A_SEL:                reg_rdata[SEL_W-1:0] = sel_q;
      A_CYC:                reg_rdata[CNT_W-1:0] = cyc_cnt;
      A_ETYPE:              if (sel_ok) reg_rdata[ETYPE_W-1:0] = etype_q[sel_idx];
      A_ECNT:               if (sel_ok) reg_rdata[CNT_W-1:0] = ev_cnt[sel_idx];
      default:              reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmu_mon_chk.sv
module pmu_mon_chk
  import pmu_pkg::*;
#(
  parameter int NV    = 4,
  parameter int CW    = 32,
  parameter int SW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [NV:0]       flg_q,
  input logic [NV:0]       wrap_vec,
  input logic [CW-1:0]     cyc_cnt,
  input logic              glb_run,
  input logic [SW-1:0]     sel_q
);
  AST_CTRL_PULSE_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> (reg_rdata[2:1] == 2'b00 && reg_rdata[31:6] == '0)); // R2

  AST_IDLE_HOLDS_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_run && !(reg_we && (reg_addr == A_CYC || reg_addr == A_CTRL))) |=> $stable(cyc_cnt)); // R5

  AST_WRAP_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((flg_q & $past(wrap_vec)) == $past(wrap_vec))); // R8

  AST_W1C_FLAG0: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_FLAGS && reg_wdata[0] && !wrap_vec[0]) |=> !flg_q[0]); // R8

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flg_q)); // R9

  AST_SEL_HI_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_ECNT && sel_q >= SW'(NV)) |-> (reg_rdata == '0)); // R10
endmodule

bind perf_mon_unit pmu_mon_chk #(.NV(NUM_EVT), .CW(CNT_W), .SW(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .flg_q     (flg_q),
  .wrap_vec  (wrap_vec),
  .cyc_cnt   (cyc_cnt),
  .glb_run   (ctrl_q[0]),
  .sel_q     (sel_q)
);

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb_top;
  logic         clk;
  logic         rst_n;
  logic [3:0]   reg_addr;
  logic         reg_we;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [127:0] evt_in;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  perf_mon_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  typedef struct packed {
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] ex;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd0, 32'hFFFF_FFFF, 4'd0, 32'h0000_0039},  // R2 stored bits only
    '{4'd0, 32'h0000_0000, 4'd0, 32'h0000_0000},  // R2
    '{4'd1, 32'hFFFF_FFFF, 4'd1, 32'h8000_000F},  // R4 set mask
    '{4'd2, 32'h0000_0005, 4'd2, 32'h8000_000A},  // R4 partial clear
    '{4'd2, 32'hFFFF_FFFF, 4'd1, 32'h0000_0000},  // R4 full clear
    '{4'd3, 32'h8000_0003, 4'd3, 32'h8000_0003},  // R4 irq enable set
    '{4'd4, 32'h8000_0000, 4'd4, 32'h0000_0003},  // R4 irq enable clear
    '{4'd4, 32'h0000_000F, 4'd3, 32'h0000_0000},  // R4
    '{4'd6, 32'h0000_00FF, 4'd6, 32'h0000_001F},  // R10 5-bit select
    '{4'd6, 32'h0000_0002, 4'd6, 32'h0000_0002},  // R10
    '{4'd8, 32'h0000_0FFF, 4'd8, 32'h0000_007F},  // R10 7-bit type
    '{4'd9, 32'h1234_5678, 4'd9, 32'h1234_5678},  // R11 event count write
    '{4'd7, 32'hCAFE_F00D, 4'd7, 32'hCAFE_F00D}   // R11 cycle count write
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // drive a write; the register updates on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk);
    #2;
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; evt_in = '0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(posedge clk); #2;

    // R1: reset state
    for (int a = 0; a < 10; a++) rchk("R1 reg after reset", 4'(a), 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // table walk: write then read back
    for (int k = 0; k < NV; k++) begin
      wr(TBL[k].wa, TBL[k].wd);
      rchk($sformatf("table row %0d (R2/R4/R10/R11)", k), TBL[k].ra, TBL[k].ex);
    end

    // R10: select above 3 hides the selected-counter registers
    wr(4'd6, 32'd4);
    wr(4'd9, 32'h0000_DEAD);
    wr(4'd8, 32'h0000_0011);
    rchk("R10 count with sel 4", 4'd9, 32'h0);
    rchk("R10 type with sel 4", 4'd8, 32'h0);
    wr(4'd6, 32'd2);
    rchk("R10 count untouched", 4'd9, 32'h1234_5678);
    rchk("R10 type untouched", 4'd8, 32'h0000_007F);

    // R3: reset pulses
    wr(4'd0, 32'h2);
    rchk("R3 event reset", 4'd9, 32'h0);
    rchk("R3 cycle kept", 4'd7, 32'hCAFE_F00D);
    wr(4'd0, 32'h4);
    rchk("R3 cycle reset", 4'd7, 32'h0);
    rchk("R3 pulses read zero", 4'd0, 32'h0);

    // R6: event counting on selected strobe
    wr(4'd6, 32'd0);
    wr(4'd8, 32'd5);
    wr(4'd1, 32'h1);
    wr(4'd0, 32'h1);
    evt_in[5] = 1'b1; evt_in[6] = 1'b1;
    repeat (10) @(posedge clk);
    #2 evt_in = '0;
    wr(4'd0, 32'h0);
    rchk("R6 ten events", 4'd9, 32'd10);

    // R5: gating by run bit and by own enable
    evt_in[5] = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    rchk("R5 run off holds", 4'd9, 32'd10);
    wr(4'd2, 32'h1);
    wr(4'd0, 32'h1);
    repeat (5) @(posedge clk);
    #2 evt_in = '0;
    wr(4'd0, 32'h0);
    rchk("R5 enable off holds", 4'd9, 32'd10);

    // R7: cycle counter, divided and undivided
    wr(4'd7, 32'h0);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h4);
    wr(4'd0, 32'h9);
    repeat (127) @(posedge clk);
    #2;
    wr(4'd0, 32'h0);
    rchk("R7 128 clocks divided", 4'd7, 32'd2);
    wr(4'd0, 32'h4);
    wr(4'd0, 32'h1);
    repeat (9) @(posedge clk);
    #2;
    wr(4'd0, 32'h0);
    rchk("R7 10 clocks undivided", 4'd7, 32'd10);
    wr(4'd2, 32'h8000_0000);

    // R11: load beats a same-cycle increment
    wr(4'd1, 32'h1);
    wr(4'd0, 32'h1);
    evt_in[5] = 1'b1;
    wr(4'd9, 32'h100);
    evt_in = '0;
    wr(4'd0, 32'h0);
    rchk("R11 load wins", 4'd9, 32'h100);

    // R8 / R9: wrap, sticky flag, interrupt gating
    wr(4'd6, 32'd1);
    wr(4'd8, 32'd7);
    wr(4'd9, 32'hFFFF_FFFE);
    wr(4'd1, 32'h2);
    wr(4'd3, 32'h2);
    wr(4'd0, 32'h1);
    evt_in[7] = 1'b1;
    repeat (2) @(posedge clk);
    #2 evt_in = '0;
    wr(4'd0, 32'h0);
    rchk("R8 count wrapped", 4'd9, 32'h0);
    rchk("R8 flag set", 4'd5, 32'h2);
    chk("R9 irq with enable", {31'b0, irq}, 32'h1);
    wr(4'd4, 32'h2);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    rchk("R8 flag sticky", 4'd5, 32'h2);
    wr(4'd3, 32'h2);
    chk("R9 irq unmasked", {31'b0, irq}, 32'h1);
    wr(4'd5, 32'h2);
    rchk("R8 flag cleared", 4'd5, 32'h0);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);

    // R8: wrap and clear in the same cycle, set wins
    evt_in[7] = 1'b1;
    wr(4'd0, 32'h1);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd5, 32'h2);
    evt_in = '0;
    wr(4'd0, 32'h0);
    rchk("R8 set beats clear", 4'd5, 32'h2);
    chk("R9 irq held", {31'b0, irq}, 32'h1);
    rchk("R8 count after wrap", 4'd9, 32'h0);
    wr(4'd5, 32'hFFFF_FFFF);
    rchk("R8 all flags cleared", 4'd5, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule